// File: doc/BRIEF.md
# Dual Auxiliary PWM Generator

This block drives two pulse-width-modulated outputs, `aux0` and `aux1`, from a small register set written over a plain address/data/strobe port. Time advances only on a clock-enable pulse, `tick`. Each tick is one base time unit. The internal counters step once for every two ticks, so every period and every high time is an even number of ticks.

The block has two modes. In independent mode each output has its own period register and its own on-time register. In offset mode both outputs run at the period of channel 0. The period register of channel 1 then sets the delay from a rising edge of `aux0` to the next rising edge of `aux1`. The high interval of `aux1` may wrap across the shared period boundary.

New on-time values are held back until the next cycle of their channel begins, so a cycle in progress is never cut short or stretched. A write to either period register, or to the mode register, restarts both timers at once.

Top module: `dual_aux_pwm`

## Requirements
- R1: After reset the block is in offset mode, both period registers hold 0xFF, both on-time registers hold 0x00, and both outputs stay low.
- R2: The counters step once per two `tick` pulses. A channel whose period register holds P repeats every 2·(P+1) ticks. With `tick` held high this is 2·(P+1) clock cycles.
- R3: A channel whose on-time register holds C is high for 2·C ticks per cycle, starting at the cycle start. C = 0 keeps the output low.
- R4: When C is greater than P (C ≥ P+1), the output stays high for the whole cycle.
- R5: Register addresses are 0 = period 0, 1 = period 1, 2 = on-time 0, 3 = on-time 1, 4 = mode. Bit 0 of the mode register selects independent mode when 1 and offset mode when 0. In independent mode channel 1 uses its own period and on-time registers.
- R6: In offset mode both outputs repeat at the period of channel 0. Each `aux1` rising edge comes 2·(P1+1) ticks after an `aux0` rising edge. This holds provided P1 < P0.
- R7: In offset mode a high interval of `aux1` that runs past the end of the shared period continues into the next period. `aux1` still rises exactly once per period.
- R8: A write to an on-time register leaves the cycle in progress unchanged. It takes effect from the next cycle of that channel.
- R9: A write to address 0, 1 or 4 restarts both timers on the second clock edge after the strobe. At that restart, channel 0 begins a new cycle at once, high if its on-time is non-zero. In offset mode channel 1 starts counting its delay from that moment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable; one pulse is one base time unit |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| aux0 | output | 1 | PWM output of channel 0 |
| aux1 | output | 1 | PWM output of channel 1 |

## Verification
A counter that steps at the wrong rate or wraps at the wrong limit changes the rise-to-rise spacing. This shows within one period of the affected output. A stale or early-loaded on-time shadow changes the count of high cycles in the cycle that follows a write. That error is confined to a single period, so the bench counts highs over windows that line up with the write. A wrong offset preload in the second channel moves every `aux1` edge by a fixed amount for as long as offset mode runs. A missing restart shows as an output that is not high on the cycle right after a period write.

// File: rtl/aux_pwm_pkg.sv
package aux_pwm_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_PER0 = 3'd0,
    ADDR_PER1 = 3'd1,
    ADDR_ON0  = 3'd2,
    ADDR_ON1  = 3'd3,
    ADDR_MODE = 3'd4
  } auxAddr_t;

  typedef struct packed {
    logic restart;
    logic advance;
  } auxStrobe_t;

endpackage

// File: rtl/aux_pwm_ctrl.sv
module aux_pwm_ctrl
  import aux_pwm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DW-1:0]     wrData,
  output auxStrobe_t        strb,
  output logic [DW-1:0]     per0,
  output logic [DW-1:0]     per1,
  output logic [DW-1:0]     on0,
  output logic [DW-1:0]     on1,
  output logic              modeIndep
);

  localparam logic [DW-1:0] PER_RESET = '1;

  auxAddr_t addrQ;
  logic     restartQ;
  logic     phase;
  logic     hitsTimer;

  assign addrQ     = auxAddr_t'(wrAddr);
  assign hitsTimer = wrEn && (addrQ == ADDR_PER0 || addrQ == ADDR_PER1 ||
                              addrQ == ADDR_MODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      per0      <= PER_RESET;
      per1      <= PER_RESET;
      on0       <= '0;
      on1       <= '0;
      modeIndep <= 1'b0;
    end else if (wrEn) begin
      unique case (addrQ)
        ADDR_PER0: per0      <= wrData;
        ADDR_PER1: per1      <= wrData;
        ADDR_ON0:  on0       <= wrData;
        ADDR_ON1:  on1       <= wrData;
        ADDR_MODE: modeIndep <= wrData[0];
        default:   ;
      endcase
    end
  end

  // restart is issued one cycle after the write so that the datapath
  // loads its start values from the already-updated registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      restartQ <= 1'b0;
      phase    <= 1'b0;
    end else begin
      restartQ <= hitsTimer;
      if (restartQ)  phase <= 1'b0;
      else if (tick) phase <= ~phase;
    end
  end

  assign strb.restart = restartQ;
  assign strb.advance = tick && phase && !restartQ;

  assert_advance_half_rate_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> !strb.advance);

  assert_restart_clears_phase_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> !strb.advance);

endmodule

// File: rtl/aux_pwm_channel.sv
module aux_pwm_channel #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          restart,
  input  logic          advance,
  input  logic [DW-1:0] limit,
  input  logic [DW-1:0] startCnt,
  input  logic [DW-1:0] startOn,
  input  logic [DW-1:0] onReg,
  output logic [DW-1:0] cnt,
  output logic          pwmOut
);

  logic [DW-1:0] onQ;
  logic          atEnd;

  assign atEnd = (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      onQ <= '0;
    end else if (restart) begin
      cnt <= startCnt;
      onQ <= startOn;
    end else if (advance) begin
      if (atEnd) begin
        cnt <= '0;
        onQ <= onReg;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign pwmOut = (cnt < onQ);

  assert_rise_at_cycle_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> (cnt == '0));

endmodule

// File: rtl/aux_pwm_datapath.sv
module aux_pwm_datapath
  import aux_pwm_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CHANS = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  auxStrobe_t    strb,
  input  logic [DW-1:0] per0,
  input  logic [DW-1:0] per1,
  input  logic [DW-1:0] on0,
  input  logic [DW-1:0] on1,
  input  logic          modeIndep,
  output logic [CHANS-1:0] pwm
);

  logic [DW-1:0] limit    [CHANS];
  logic [DW-1:0] startCnt [CHANS];
  logic [DW-1:0] startOn  [CHANS];
  logic [DW-1:0] onReg    [CHANS];
  logic [DW-1:0] cnt      [CHANS];

  always_comb begin
    limit[0]    = per0;
    startCnt[0] = '0;
    startOn[0]  = on0;
    onReg[0]    = on0;
    // offset mode: channel 1 shares period 0 and is preloaded so that
    // it wraps exactly per1+1 steps after channel 0 does
    limit[1]    = modeIndep ? per1 : per0;
    startCnt[1] = modeIndep ? '0 : (per0 - per1);
    startOn[1]  = modeIndep ? on1 : '0;
    onReg[1]    = on1;
  end

  for (genvar g = 0; g < CHANS; g++) begin : gChan
    aux_pwm_channel #(.DW(DW)) uChan (
      .clk      (clk),
      .rstN     (rstN),
      .restart  (strb.restart),
      .advance  (strb.advance),
      .limit    (limit[g]),
      .startCnt (startCnt[g]),
      .startOn  (startOn[g]),
      .onReg    (onReg[g]),
      .cnt      (cnt[g]),
      .pwmOut   (pwm[g])
    );
  end

  assert_restart_zeroes_timer_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (cnt[0] == '0));

  assert_offset_alignment_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!modeIndep && (per1 < per0) && !strb.restart && !$stable(cnt[0]) &&
     (cnt[0] == per1 + 1'b1)) |-> (cnt[1] == '0));

endmodule

// File: rtl/dual_aux_pwm.sv
module dual_aux_pwm
  import aux_pwm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          wrEn,
  input  logic [2:0]    wrAddr,
  input  logic [DW-1:0] wrData,
  output logic          aux0,
  output logic          aux1
);

  auxStrobe_t    strb;
  logic [DW-1:0] per0, per1, on0, on1;
  logic          modeIndep;
  logic [1:0]    pwm;

  aux_pwm_ctrl #(.DW(DW)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strb      (strb),
    .per0      (per0),
    .per1      (per1),
    .on0       (on0),
    .on1       (on1),
    .modeIndep (modeIndep)
  );

  aux_pwm_datapath #(.DW(DW), .CHANS(2)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .per0      (per0),
    .per1      (per1),
    .on0       (on0),
    .on1       (on1),
    .modeIndep (modeIndep),
    .pwm       (pwm)
  );

  assign aux0 = pwm[0];
  assign aux1 = pwm[1];

endmodule

// File: tb/dual_aux_pwm_test.sv
module dual_aux_pwm_test;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 6;

  // mode, per0, per1, on0, on1, expected highs per period (ch0, ch1), expected delay (0 = skip)
  localparam int vMode [VEC_N] = '{1, 1, 1, 0, 0, 0};
  localparam int vPer0 [VEC_N] = '{4, 3, 6, 9, 9, 15};
  localparam int vPer1 [VEC_N] = '{7, 0, 2, 3, 5, 0};
  localparam int vOn0  [VEC_N] = '{2, 9, 0, 3, 1, 4};
  localparam int vOn1  [VEC_N] = '{5, 1, 2, 2, 6, 4};
  localparam int vHi0  [VEC_N] = '{4, 8, 0, 6, 2, 8};
  localparam int vHi1  [VEC_N] = '{10, 2, 4, 4, 12, 8};
  localparam int vDly  [VEC_N] = '{0, 0, 0, 8, 0, 2};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b1;
  logic       slowTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       aux0, aux1;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_aux_pwm uut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .aux0(aux0), .aux1(aux1)
  );

  initial begin
    forever begin
      @(negedge clk);
      tick = slowTick ? ~tick : 1'b1;
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a[2:0]; wrData = d[7:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic skip(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(int sel, int n, output int hi, output int rises);
    logic prevv, cur;
    prevv = sel ? aux1 : aux0;
    hi = 0; rises = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur = sel ? aux1 : aux0;
      hi += int'(cur);
      if (cur && !prevv) rises++;
      prevv = cur;
    end
  endtask

  task automatic waitRise0(output int ok);
    logic prevv;
    prevv = aux0;
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (aux0 && !prevv) begin ok = 1; return; end
      prevv = aux0;
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int hi, rises, ok, n, lo, mism, h1;
    // ---------------- R1 reset defaults ----------------
    skip(5);
    check("R1 aux0 in reset", int'(aux0), 0);
    check("R1 aux1 in reset", int'(aux1), 0);
    rstN = 1'b1;
    measure(0, 600, hi, rises);
    check("R1 aux0 low after reset", hi, 0);
    measure(1, 600, hi, rises);
    check("R1 aux1 low after reset", hi, 0);
    // default period 0xFF (512 cycles), offset mode with zero lag
    wr(2, 5);
    wr(3, 5);
    skip(530);
    hi = 0; h1 = 0; mism = 0; rises = 0;
    begin
      logic prevv;
      prevv = aux0;
      for (int i = 0; i < 512; i++) begin
        @(negedge clk);
        hi += int'(aux0);
        h1 += int'(aux1);
        if (aux0 != aux1) mism++;
        if (aux0 && !prevv) rises++;
        prevv = aux0;
      end
    end
    check("R1 default period high count", hi, 10);
    check("R1 default period rises", rises, 1);
    check("R1 default offset aux1 high", h1, 10);
    check("R1 default zero lag mismatch", mism, 0);

    // ---------------- table of vectors (R2..R7) ----------------
    for (int v = 0; v < VEC_N; v++) begin
      int p0, p1;
      wr(2, vOn0[v]);
      wr(3, vOn1[v]);
      wr(4, vMode[v]);
      wr(1, vPer1[v]);
      wr(0, vPer0[v]);
      p0 = 2 * (vPer0[v] + 1);
      p1 = (vMode[v] != 0) ? 2 * (vPer1[v] + 1) : p0;
      skip(2 * p0 + 2 * p1 + 8);
      measure(0, p0, hi, rises);
      check($sformatf("R3 R4 vec%0d aux0 highs", v), hi, vHi0[v]);
      measure(1, p1, hi, rises);
      check($sformatf("R5 R7 vec%0d aux1 highs", v), hi, vHi1[v]);
      measure(0, 4 * p0, hi, rises);
      check($sformatf("R2 vec%0d aux0 rises", v), rises,
            (vHi0[v] > 0 && vHi0[v] < p0) ? 4 : 0);
      measure(1, 4 * p1, hi, rises);
      check($sformatf("R6 R7 vec%0d aux1 rises", v), rises,
            (vHi1[v] > 0 && vHi1[v] < p1) ? 4 : 0);
      if (vDly[v] != 0) begin
        waitRise0(ok);
        n = 0;
        while (!aux1 && n < 2000) begin @(negedge clk); n++; end
        check($sformatf("R6 vec%0d aux1 lag", v), n, vDly[v]);
      end
    end

    // ---------------- R8 on-time write deferred ----------------
    wr(4, 1);
    wr(2, 2);
    wr(0, 9);
    skip(50);
    waitRise0(ok);
    hi = 1;
    for (int i = 1; i < 20; i++) begin
      if (i == 1) begin wrEn = 1'b1; wrAddr = 3'd2; wrData = 8'd8; end
      if (i == 2) wrEn = 1'b0;
      @(negedge clk);
      hi += int'(aux0);
    end
    check("R8 cycle in progress keeps old on-time", hi, 4);
    measure(0, 20, hi, rises);
    check("R8 next cycle uses new on-time", hi, 16);

    // ---------------- R9 period write restarts ----------------
    wr(2, 3);
    skip(50);
    waitRise0(ok);
    skip(10);
    check("R9 low before restart", int'(aux0), 0);
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'd5;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
    check("R9 high right after restart", int'(aux0), 1);
    hi = 0;
    while (aux0 && hi < 200) begin hi++; @(negedge clk); end
    check("R9 high run after restart", hi, 6);
    lo = 0;
    while (!aux0 && lo < 200) begin lo++; @(negedge clk); end
    check("R9 low run after restart", lo, 6);

    // ---------------- R2 sparse tick ----------------
    slowTick = 1'b1;
    wr(2, 1);
    wr(0, 3);
    skip(80);
    measure(0, 64, hi, rises);
    check("R2 half-rate tick highs", hi, 16);
    check("R2 half-rate tick rises", rises, 4);
    slowTick = 1'b0;

    finishRun();
  end

endmodule